// File: doc/BRIEF.md
# Register List Stack Sequencer

This block moves a chosen set of processor registers between the register file and a word-addressed stack, one 32-bit word per cycle. It serves push-multiple and pop-multiple, and the register save and restore steps of call and return. An 8-bit list mask picks the registers. A start pulse launches the operation with a direction (save or restore), the mask, the current stack pointer and a frame size. The frame size is used only on restore, where it is added to the stack pointer before the first read.

On save, the sequencer asks the register file for each selected register through a read index. It writes that register to memory at a pointer that drops by four bytes ahead of every word. On restore, it reads memory at a rising pointer and returns each word to the register file through a write strobe with an index. The memory port is a plain request/valid pair, and the sequencer holds its request until valid returns. At the end it gives a one-cycle done pulse and holds the final stack pointer on its output.

Register index encoding on both register ports: D0=0, D1=1, D2=2, D3=3, A0=4, A1=5, A2=6, A3=7, MDR=8, LIR=9, LAR=10.

Top module: `regmask_stack_seq`

## Requirements
- R1: Mask bit 7 selects D2, bit 6 selects D3, bit 5 selects A2, bit 4 selects A3, and bit 3 selects the group D0, D1, A0, A1, MDR, LIR, LAR. Mask bits 2..0 have no effect. Register indices use the encoding given above.
- R2: A save (restore_i=0) writes in the order D2, D3, A2, A3, then the group in the order D0, D1, A0, A1, MDR, LIR, LAR, skipping registers that are not selected. The first word goes to sp_i-4 and each following word goes 4 lower. Write data is reg_rd_data_i for the index shown on reg_rd_idx_o, and reg_we_o stays low.
- R3: A restore (restore_i=1) reads in the order LAR, LIR, MDR, A1, A0, D1, D0, A3, A2, D3, D2, skipping registers that are not selected. The first address is sp_i+frame_i and each following address is 4 higher. Each accepted word pulses reg_we_o with its index and mem_rdata_i.
- R4: frame_i is added, zero-extended, to the start pointer on restore only. It has no effect on a save.
- R5: done_o is high for exactly one cycle after the last word is accepted. sp_o then equals the start pointer (sp_i, or sp_i+frame_i on restore), minus 4 per word on save or plus 4 per word on restore.
- R6: A start whose mask has bits 7..3 all zero raises done_o in the next cycle and issues no memory request.
- R7: While mem_req_o is high and mem_valid_i is low, the address, the direction and the transfer in progress stay unchanged, and no register strobe is given.
- R8: start_i is ignored while busy_o is high.
- R9: After reset, mem_req_o, done_o, busy_o and reg_we_o are low and sp_o is zero.
- R10: With mem_valid_i high on every request, an operation of N words raises done_o N+1 cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| restore_i | input | 1 | 0 = save to stack, 1 = restore from stack |
| mask_i | input | 8 | Register list mask |
| sp_i | input | 32 | Stack pointer at start |
| frame_i | input | 8 | Frame size added on restore |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 32 | Final stack pointer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (save) |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_valid_i | input | 1 | Memory completes the current request |
| mem_rdata_i | input | 32 | Memory read data |
| reg_rd_idx_o | output | 4 | Register file read index (save) |
| reg_rd_data_i | input | 32 | Register file read data |
| reg_we_o | output | 1 | Register file write strobe (restore) |
| reg_wr_idx_o | output | 4 | Register file write index |
| reg_wr_data_o | output | 32 | Register file write data |

## Verification
The bench goes after the mirrored visiting orders, because a design that walked a restore in save order would load LAR's slot into D2 and scramble every frame. Full, single-bit and group-only masks are run with and without wait states. A design that advanced on a stalled cycle would skip words, and a stall test would show it as a wrong address or a lost strobe. Empty and low-bit-only masks check that nothing reaches memory. A frame size given on save checks that it does not shift the pointer. A second start during a run must not change the transfer list.

// File: rtl/rls_pkg.sv
// Shared constants and helpers for the register list stack sequencer.
// Slot k of the internal list is the k-th register in save order.
package rls_pkg;

    localparam int NUM_SLOTS = 11;
    localparam int IDX_W     = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    typedef enum logic [IDX_W-1:0] {
        RIX_D0 = 4'd0, RIX_D1 = 4'd1, RIX_D2 = 4'd2, RIX_D3 = 4'd3,
        RIX_A0 = 4'd4, RIX_A1 = 4'd5, RIX_A2 = 4'd6, RIX_A3 = 4'd7,
        RIX_MDR = 4'd8, RIX_LIR = 4'd9, RIX_LAR = 4'd10
    } reg_idx_e;

    // Map a slot (save order position) to a register file index.
    function automatic logic [IDX_W-1:0] slot_reg(input logic [SLOT_W-1:0] s);
        case (s)
            4'd0:    slot_reg = RIX_D2;
            4'd1:    slot_reg = RIX_D3;
            4'd2:    slot_reg = RIX_A2;
            4'd3:    slot_reg = RIX_A3;
            4'd4:    slot_reg = RIX_D0;
            4'd5:    slot_reg = RIX_D1;
            4'd6:    slot_reg = RIX_A0;
            4'd7:    slot_reg = RIX_A1;
            4'd8:    slot_reg = RIX_MDR;
            4'd9:    slot_reg = RIX_LIR;
            default: slot_reg = RIX_LAR;
        endcase
    endfunction

endpackage

// File: rtl/rls_slot_expand.sv
// Expands the 8-bit register list mask into one pending bit per slot.
// Assumes: bits 2..0 of the mask carry no selection and are discarded.
module rls_slot_expand
    import rls_pkg::*;
#(
    parameter int MASK_W = 8,
    parameter int GROUP_N = 7
) (
    input  logic [MASK_W-1:0]    mask,
    output logic [NUM_SLOTS-1:0] slots
);
    localparam int SINGLE_N = NUM_SLOTS - GROUP_N;

    logic [MASK_W-1:0] used;

    // Keep only the selecting bits.
    assign used = mask & 8'hF8;

    genvar k;
    generate
        for (k = 0; k < SINGLE_N; k++) begin : g_single
            // Single registers: slot 0 follows mask bit 7, descending.
            assign slots[k] = used[MASK_W-1-k];
        end
        for (k = SINGLE_N; k < NUM_SLOTS; k++) begin : g_group
            // Group registers all follow the one group bit.
            assign slots[k] = used[MASK_W-1-SINGLE_N];
        end
    endgenerate
endmodule

// File: rtl/rls_slot_pick.sv
// Picks one pending slot: the lowest when FROM_TOP is 0 (save order),
// the highest when FROM_TOP is 1 (restore order).
// Assumes: output is don't-care when no slot is pending.
module rls_slot_pick #(
    parameter int N        = 11,
    parameter bit FROM_TOP = 1'b0,
    localparam int W       = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic [N-1:0] sel_oh,
    output logic [W-1:0] sel_idx
);
    generate
        if (FROM_TOP) begin : g_high
            // Priority scan from the top slot downward.
            always_comb begin
                logic found;
                found   = 1'b0;
                sel_oh  = '0;
                sel_idx = '0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (vec[i] && !found) begin
                        found     = 1'b1;
                        sel_oh[i] = 1'b1;
                        sel_idx   = W'(i);
                    end
                end
            end
        end else begin : g_low
            // Priority scan from slot zero upward.
            always_comb begin
                logic found;
                found   = 1'b0;
                sel_oh  = '0;
                sel_idx = '0;
                for (int i = 0; i < N; i++) begin
                    if (vec[i] && !found) begin
                        found     = 1'b1;
                        sel_oh[i] = 1'b1;
                        sel_idx   = W'(i);
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/rls_ptr_step.sv
// Computes the access address and the next pointer for one word.
// Save: pre-decrement. Restore: access at pointer, then increment.
module rls_ptr_step #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              restore,
    input  logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] next_ptr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    // Select address and pointer update by direction.
    always_comb begin
        if (restore) begin
            acc_addr = ptr;
            next_ptr = ptr + STEP;
        end else begin
            acc_addr = ptr - STEP;
            next_ptr = ptr - STEP;
        end
    end
endmodule

// File: rtl/regmask_stack_seq.sv
// Register list stack sequencer: saves or restores the registers picked by
// an 8-bit mask, one word per accepted memory cycle.
// Assumes: register read data is combinational from reg_rd_idx_o; memory
// completes a request in the cycle mem_valid_i is high.
module regmask_stack_seq
    import rls_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int FRAME_W    = 8,
    parameter int MASK_W     = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              restore_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_valid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [IDX_W-1:0]  reg_rd_idx_o,
    input  logic [DATA_W-1:0] reg_rd_data_i,
    output logic              reg_we_o,
    output logic [IDX_W-1:0]  reg_wr_idx_o,
    output logic [DATA_W-1:0] reg_wr_data_o
);
    logic [NUM_SLOTS-1:0] pend_q, start_slots, pend_next;
    logic [NUM_SLOTS-1:0] lo_oh, hi_oh, cur_oh;
    logic [SLOT_W-1:0]    lo_idx, hi_idx, cur_slot;
    logic [ADDR_W-1:0]    ptr_q, acc_addr, next_ptr, start_ptr;
    logic                 dir_q, busy_q, done_q, xfer;
    logic [IDX_W-1:0]     cur_reg;

    rls_slot_expand #(.MASK_W(MASK_W)) u_expand (
        .mask  (mask_i),
        .slots (start_slots)
    );

    rls_slot_pick #(.N(NUM_SLOTS), .FROM_TOP(1'b0)) u_pick_lo (
        .vec (pend_q), .sel_oh (lo_oh), .sel_idx (lo_idx)
    );

    rls_slot_pick #(.N(NUM_SLOTS), .FROM_TOP(1'b1)) u_pick_hi (
        .vec (pend_q), .sel_oh (hi_oh), .sel_idx (hi_idx)
    );

    rls_ptr_step #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_step (
        .restore  (dir_q),
        .ptr      (ptr_q),
        .acc_addr (acc_addr),
        .next_ptr (next_ptr)
    );

    // Current slot: lowest pending on save, highest pending on restore.
    always_comb begin
        cur_oh   = dir_q ? hi_oh  : lo_oh;
        cur_slot = dir_q ? hi_idx : lo_idx;
        cur_reg  = slot_reg(cur_slot);
    end

    assign xfer      = busy_q & mem_valid_i;
    assign pend_next = pend_q & ~cur_oh;
    assign start_ptr = restore_i ? sp_i + ADDR_W'(frame_i) : sp_i;

    // Sequencer state: load on idle start, retire one slot per accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            ptr_q  <= '0;
            dir_q  <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q && start_i) begin
                pend_q <= start_slots;
                dir_q  <= restore_i;
                ptr_q  <= start_ptr;
                busy_q <= |start_slots;
                done_q <= ~|start_slots;
            end else if (xfer) begin
                pend_q <= pend_next;
                ptr_q  <= next_ptr;
                if (pend_next == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o        = busy_q;
    assign done_o        = done_q;
    assign sp_o          = ptr_q;
    assign mem_req_o     = busy_q;
    assign mem_we_o      = busy_q & ~dir_q;
    assign mem_addr_o    = acc_addr;
    assign mem_wdata_o   = reg_rd_data_i;
    assign reg_rd_idx_o  = cur_reg;
    assign reg_we_o      = xfer & dir_q;
    assign reg_wr_idx_o  = cur_reg;
    assign reg_wr_data_o = mem_rdata_i;
endmodule

// File: rtl/rls_checker.sv
// Port-level properties of the register list stack sequencer.
// Assumes: attached by the bind below; reset is synchronous active-low.
module rls_checker #(
    parameter int ADDR_W     = 32,
    parameter int MASK_W     = 8,
    parameter int WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [MASK_W-1:0] mask_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_valid_i,
    input logic              reg_we_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R7

    AST_STALL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |-> !reg_we_o); // R7

    AST_SAVE_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_valid_i && mem_we_o) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) - STEP)); // R2

    AST_RESTORE_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_valid_i && !mem_we_o) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + STEP)); // R3

    AST_SAVE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> !reg_we_o); // R2

    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (mask_i & 8'hF8) == 8'h00) |=> (done_o && !mem_req_o)); // R6
endmodule

bind regmask_stack_seq rls_checker #(
    .ADDR_W(ADDR_W), .MASK_W(MASK_W), .WORD_BYTES(WORD_BYTES)
) u_rls_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mask_i      (mask_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .reg_we_o    (reg_we_o)
);

// File: tb/test_regmask_stack_seq.sv
// Scoreboard bench: the driver queues the expected transfers, and the
// memory monitor pops and compares them as the design issues them.
module test_regmask_stack_seq;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [3:0]  idx;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        restore_i = 1'b0;
    logic [7:0]  mask_i = '0;
    logic [31:0] sp_i = '0;
    logic [7:0]  frame_i = '0;
    logic        busy_o, done_o, mem_req_o, mem_we_o, reg_we_o;
    logic [31:0] sp_o, mem_addr_o, mem_wdata_o, reg_wr_data_o, reg_rd_data_i;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_valid_i = 1'b0;
    logic [3:0]  reg_rd_idx_o, reg_wr_idx_o;

    int   n_chk = 0;
    int   n_bad = 0;
    int   wait_n = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    function automatic logic [31:0] regval(input logic [3:0] idx);
        return 32'hC0DE_0000 | {28'h0, idx};
    endfunction

    function automatic logic [31:0] memval(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    // Save-order position k: mask bit and register index (R1).
    function automatic int bit_of(input int k);
        return (k < 4) ? 7 - k : 3;
    endfunction

    function automatic logic [3:0] reg_of(input int k);
        case (k)
            0: return 4'd2;  1: return 4'd3;  2: return 4'd6;  3: return 4'd7;
            4: return 4'd0;  5: return 4'd1;  6: return 4'd4;  7: return 4'd5;
            8: return 4'd8;  9: return 4'd9;  default: return 4'd10;
        endcase
    endfunction

    assign reg_rd_data_i = regval(reg_rd_idx_o);

    regmask_stack_seq i_regmask_stack_seq (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .restore_i (restore_i),
        .mask_i (mask_i), .sp_i (sp_i), .frame_i (frame_i),
        .busy_o (busy_o), .done_o (done_o), .sp_o (sp_o),
        .mem_req_o (mem_req_o), .mem_we_o (mem_we_o), .mem_addr_o (mem_addr_o),
        .mem_wdata_o (mem_wdata_o), .mem_valid_i (mem_valid_i), .mem_rdata_i (mem_rdata_i),
        .reg_rd_idx_o (reg_rd_idx_o), .reg_rd_data_i (reg_rd_data_i),
        .reg_we_o (reg_we_o), .reg_wr_idx_o (reg_wr_idx_o), .reg_wr_data_o (reg_wr_data_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model and monitor: answers after wait_n stall cycles.
    initial begin
        int   cnt;
        exp_t e;
        string r;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_req_o) begin
                if (cnt >= wait_n) begin mem_valid_i = 1'b1; cnt = 0; end
                else begin mem_valid_i = 1'b0; cnt++; end
                mem_rdata_i = memval(mem_addr_o);
            end else begin
                mem_valid_i = 1'b0;
                cnt = 0;
            end
            #1;
            if (mem_req_o) begin
                if (q.size() == 0) begin
                    chk("R6", 32'd1, 32'd0, "request with nothing expected");
                end else begin
                    e = q[0];
                    r = e.we ? "R2" : "R3";
                    chk(r, mem_addr_o, e.addr, "address");
                    chk(r, {31'd0, mem_we_o}, {31'd0, e.we}, "direction");
                    if (mem_valid_i) begin
                        if (e.we) begin
                            chk(r, {28'd0, reg_rd_idx_o}, {28'd0, e.idx}, "read index");
                            chk(r, mem_wdata_o, regval(e.idx), "write data");
                            chk(r, {31'd0, reg_we_o}, 32'd0, "strobe on save");
                        end else begin
                            chk(r, {31'd0, reg_we_o}, 32'd1, "register strobe");
                            chk(r, {28'd0, reg_wr_idx_o}, {28'd0, e.idx}, "write index");
                            chk(r, reg_wr_data_o, memval(e.addr), "write data");
                        end
                        void'(q.pop_front());
                    end else begin
                        chk("R7", {31'd0, reg_we_o}, 32'd0, "strobe while stalled");
                    end
                end
            end
        end
    end

    // Driver: queue expected transfers, start, wait for done, check result.
    task automatic run_op(input logic rst, input logic [7:0] m, input logic [31:0] sp,
                          input logic [7:0] fr, input int ws, input bit poke, input string tag);
        logic [31:0] a;
        int nw, cyc;
        wait_n = ws;
        nw = 0;
        a = rst ? sp + {24'd0, fr} : sp;
        if (!rst) begin
            for (int k = 0; k < 11; k++)
                if (m[bit_of(k)]) begin a = a - 32'd4; q.push_back('{1'b1, a, reg_of(k)}); nw++; end
        end else begin
            for (int k = 10; k >= 0; k--)
                if (m[bit_of(k)]) begin q.push_back('{1'b0, a, reg_of(k)}); a = a + 32'd4; nw++; end
        end
        @(negedge clk);
        start_i = 1'b1; restore_i = rst; mask_i = m; sp_i = sp; frame_i = fr;
        @(negedge clk);
        cyc = 1;
        if (poke) begin
            // R8: second start with other inputs while busy.
            restore_i = ~rst; mask_i = 8'hF8; sp_i = 32'h0000_9000; frame_i = 8'h40;
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        while (!done_o && cyc < 500) begin @(negedge clk); cyc++; end
        chk(tag, {31'd0, done_o}, 32'd1, "done seen");
        chk(tag, sp_o, a, "final stack pointer");
        chk(tag, q.size(), 32'd0, "all words moved");
        if (ws == 0) chk("R10", cyc, nw + 1, "cycles to done");
        @(negedge clk);
        chk("R5", {31'd0, done_o}, 32'd0, "done is one cycle");
        q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", {31'd0, mem_req_o}, 32'd0, "request after reset");
        chk("R9", {31'd0, done_o}, 32'd0, "done after reset");
        chk("R9", {31'd0, busy_o}, 32'd0, "busy after reset");
        chk("R9", {31'd0, reg_we_o}, 32'd0, "strobe after reset");
        chk("R9", sp_o, 32'd0, "sp after reset");

        run_op(1'b0, 8'h80, 32'h0000_1000, 8'h00, 0, 1'b0, "R1");  // D2 only
        run_op(1'b1, 8'h10, 32'h0000_0FF0, 8'h00, 0, 1'b0, "R1");  // A3 only
        run_op(1'b0, 8'hFF, 32'h0000_2000, 8'h00, 0, 1'b0, "R2");  // all, low bits set
        run_op(1'b1, 8'hF8, 32'h0000_2000 - 32'd44, 8'h00, 0, 1'b0, "R3");
        run_op(1'b1, 8'h48, 32'h0000_3000, 8'h10, 2, 1'b0, "R4");  // frame on restore, stalls
        run_op(1'b0, 8'h30, 32'h0000_4000, 8'h55, 1, 1'b0, "R4");  // frame ignored on save
        run_op(1'b0, 8'h07, 32'h0000_5000, 8'h00, 0, 1'b0, "R6");  // empty save
        run_op(1'b1, 8'h00, 32'h0000_5000, 8'h20, 0, 1'b0, "R6");  // empty restore
        run_op(1'b0, 8'hA0, 32'h0000_6000, 8'h00, 0, 1'b1, "R8");  // start while busy
        run_op(1'b1, 8'h08, 32'h0000_7000, 8'h04, 3, 1'b0, "R7");  // group with stalls
        run_op(1'b0, 8'h08, 32'h0000_8000, 8'h00, 0, 1'b0, "R2");  // group only

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule